// File: doc/BRIEF.md
# Interval Timer Host Port

This block is the byte-wide register front end of a three-channel interval timer. A host writes configuration words and initial counts, and reads counts and status bytes, through one 8-bit port. There are three count addresses and one control address. For each channel the block gives the counting element a 16-bit load value with a load pulse, plus that channel's mode and BCD settings. In return it takes the live count, the output level, and a pulse that says the count register has been moved into the counting element.

Reads show the live count unless a snapshot has been taken. A latch command, or the count part of a read-back command, freezes a copy of the count. That copy is held until it has been fully read or the channel is reprogrammed. A read-back command can also freeze a status byte. When both are held, the status byte is returned first and the count follows in the channel's byte format. A control word resets the channel's byte pointers and releases anything it has frozen.

Top module: `timer_host_port`

## Requirements
- R1: After reset every channel is in LSB-then-MSB format, mode 0, binary, with no snapshot held and the null-count flag clear. The mode outputs, the BCD outputs and all strobes read zero.
- R2: A write to address 3 with bits 7-6 = channel 0..2 and bits 5-4 nonzero programs that channel. Bits 5-4 select the byte format (01 LSB only, 10 MSB only, 11 LSB then MSB), bits 3-1 the mode and bit 0 BCD. The settings appear on the channel's mode and BCD outputs, and its config strobe is high for the one cycle after the write.
- R3: Count writes at address 0..2 follow the channel's format. LSB only loads {00h, byte}. MSB only loads {byte, 00h}. LSB-then-MSB takes two writes and loads only after the second. The load strobe is high for one cycle with the load value valid, and at most one channel strobes at a time.
- R4: With no snapshot held, a count read returns the selected byte of the live count at that moment.
- R5: A write to address 3 with bits 5-4 = 00 freezes the selected channel's count. The frozen value is returned until the last byte of the format has been read, or until a control word reprograms the channel. After that, reads follow the live count again.
- R6: A latch command to a channel whose count is already frozen has no effect on the held value.
- R7: A write to address 3 with bits 7-6 = 11 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 freezes the count and bit 4 = 0 freezes the status of each selected channel. An item that is already frozen is left untouched.
- R8: The status byte holds the output level in bit 7, the null-count flag in bit 6, the format in bits 5-4, the mode in bits 3-1 and BCD in bit 0.
- R9: When a status byte is held, the next read of that channel returns it, without moving the count byte pointer. The following reads return the count.
- R10: The null-count flag is set by a control word or a count byte write, and is cleared by the channel's count-taken pulse when no write occurs in the same cycle.
- R11: A control word resets the channel's write and read byte pointers to LSB.
- R12: A read at address 3 returns 00h and changes no pointer or snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | 0..2 channel count port, 3 control port |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte; pointers advance at the clock edge |
| bus_rdata | output | 8 | Read data for the addressed port, valid while the address is held |
| ch_live_count | input | 48 | Live count of each channel, channel 0 in the low 16 bits |
| ch_out_level | input | 3 | Output level of each channel |
| ch_cr_taken | input | 3 | Pulse: count register moved into the counting element |
| ch_load_value | output | 48 | Count register of each channel |
| ch_load_strobe | output | 3 | One-cycle pulse when a complete count has been written |
| ch_cfg_strobe | output | 3 | One-cycle pulse when a control word has programmed the channel |
| ch_mode | output | 9 | Mode of each channel, 3 bits each |
| ch_bcd | output | 3 | BCD select of each channel |

## Verification
The assertions assume that the host performs at most one bus access per cycle and never asserts write and read together. They also assume that each strobe covers exactly one byte. The bench drives every strobe for a single cycle from the falling edge, spaces accesses apart, and pulses the count-taken inputs only between bus accesses. Under these conditions a latch command and a read of the same channel cannot land in the same cycle, which is what the properties on snapshot and pointer behaviour rely on.

// File: rtl/timer_host_pkg.sv
package timer_host_pkg;

   typedef enum logic [1:0] {
      RW_LATCH = 2'b00,
      RW_LSB   = 2'b01,
      RW_MSB   = 2'b10,
      RW_BOTH  = 2'b11
   } rw_fmt_e;

   localparam logic [1:0] SEL_READBACK = 2'b11;
   localparam int         RB_NO_COUNT  = 5;
   localparam int         RB_NO_STATUS = 4;
   localparam int         MODE_W       = 3;

   typedef struct packed {
      logic [1:0]        sel;
      rw_fmt_e           fmt;
      logic [MODE_W-1:0] mode;
      logic              bcd;
   } ctrl_word_t;

   function automatic logic [7:0] pack_status(input logic out_lvl,
                                              input logic null_flag,
                                              input rw_fmt_e fmt,
                                              input logic [MODE_W-1:0] mode,
                                              input logic bcd);
      return {out_lvl, null_flag, fmt, mode, bcd};
   endfunction

endpackage

// File: rtl/thp_cmd_decode.sv
module thp_cmd_decode
   import timer_host_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [NUM_CH-1:0] cfg_cmd,
   output logic [NUM_CH-1:0] cnt_wr,
   output logic [NUM_CH-1:0] cnt_latch,
   output logic [NUM_CH-1:0] st_latch,
   output logic [NUM_CH-1:0] rd_pop,
   output rw_fmt_e           cw_fmt,
   output logic [MODE_W-1:0] cw_mode,
   output logic              cw_bcd
);
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'((1 << ADDR_W) - 1);

   ctrl_word_t cw;
   logic       ctrl_wr;
   logic       is_rb;

   assign cw      = ctrl_word_t'(bus_wdata[7:0]);
   assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);
   assign is_rb   = (cw.sel == SEL_READBACK);
   assign cw_fmt  = cw.fmt;
   assign cw_mode = cw.mode;
   assign cw_bcd  = cw.bcd;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel_me;
      logic rb_me;
      assign sel_me       = !is_rb && (cw.sel == 2'(i));
      assign rb_me        = is_rb && bus_wdata[i+1];
      assign cfg_cmd[i]   = ctrl_wr && sel_me && (cw.fmt != RW_LATCH);
      assign cnt_latch[i] = ctrl_wr && ((sel_me && (cw.fmt == RW_LATCH)) ||
                                        (rb_me && !bus_wdata[RB_NO_COUNT]));
      assign st_latch[i]  = ctrl_wr && rb_me && !bus_wdata[RB_NO_STATUS];
      assign cnt_wr[i]    = bus_wr && (bus_addr == ADDR_W'(i));
      assign rd_pop[i]    = bus_rd && !bus_wr && (bus_addr == ADDR_W'(i));
   end

endmodule

// File: rtl/thp_channel.sv
module thp_channel
   import timer_host_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int CNT_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cmd,
   input  rw_fmt_e           cw_fmt,
   input  logic [MODE_W-1:0] cw_mode,
   input  logic              cw_bcd,
   input  logic              cnt_wr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              cnt_latch,
   input  logic              st_latch,
   input  logic              rd_pop,
   input  logic [CNT_W-1:0]  live_count,
   input  logic              out_level,
   input  logic              cr_taken,
   output logic [CNT_W-1:0]  load_value,
   output logic              load_pulse,
   output logic              cfg_pulse,
   output logic [MODE_W-1:0] mode,
   output logic              bcd,
   output logic [BYTE_W-1:0] rd_byte
);
   rw_fmt_e           fmt_q;
   logic [MODE_W-1:0] mode_q;
   logic              bcd_q;
   logic [CNT_W-1:0]  cr_q;
   logic              wr_hi_q;
   logic              rd_hi_q;
   logic              frozen_q;
   logic [CNT_W-1:0]  hold_q;
   logic              st_valid_q;
   logic [7:0]        st_q;
   logic              null_q;
   logic              load_q;
   logic              cfg_q;

   logic [CNT_W-1:0]  cnt_view;
   logic              pick_hi;
   logic [BYTE_W-1:0] cnt_byte;
   logic [7:0]        status_now;

   assign status_now = pack_status(out_level, null_q, fmt_q, mode_q, bcd_q);

   always_comb begin
      cnt_view = frozen_q ? hold_q : live_count;
      pick_hi  = (fmt_q == RW_MSB) || ((fmt_q == RW_BOTH) && rd_hi_q);
      cnt_byte = pick_hi ? cnt_view[CNT_W-1:BYTE_W] : cnt_view[BYTE_W-1:0];
      rd_byte  = st_valid_q ? BYTE_W'(st_q) : cnt_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q      <= RW_BOTH;
         mode_q     <= '0;
         bcd_q      <= 1'b0;
         cr_q       <= '0;
         wr_hi_q    <= 1'b0;
         rd_hi_q    <= 1'b0;
         frozen_q   <= 1'b0;
         hold_q     <= '0;
         st_valid_q <= 1'b0;
         st_q       <= '0;
         null_q     <= 1'b0;
         load_q     <= 1'b0;
         cfg_q      <= 1'b0;
      end else begin
         load_q <= 1'b0;
         cfg_q  <= 1'b0;
         if (cfg_cmd) begin
            fmt_q      <= cw_fmt;
            mode_q     <= cw_mode;
            bcd_q      <= cw_bcd;
            wr_hi_q    <= 1'b0;
            rd_hi_q    <= 1'b0;
            frozen_q   <= 1'b0;
            st_valid_q <= 1'b0;
            null_q     <= 1'b1;
            cfg_q      <= 1'b1;
         end else begin
            if (cnt_wr) begin
               null_q <= 1'b1;
               case (fmt_q)
                  RW_LSB: begin
                     cr_q   <= {{BYTE_W{1'b0}}, wdata};
                     load_q <= 1'b1;
                  end
                  RW_MSB: begin
                     cr_q   <= {wdata, {BYTE_W{1'b0}}};
                     load_q <= 1'b1;
                  end
                  RW_BOTH: begin
                     if (!wr_hi_q) begin
                        cr_q[BYTE_W-1:0] <= wdata;
                        wr_hi_q          <= 1'b1;
                     end else begin
                        cr_q[CNT_W-1:BYTE_W] <= wdata;
                        wr_hi_q              <= 1'b0;
                        load_q               <= 1'b1;
                     end
                  end
                  default: ;
               endcase
            end else if (cr_taken) begin
               null_q <= 1'b0;
            end
            if (cnt_latch && !frozen_q) begin
               frozen_q <= 1'b1;
               hold_q   <= live_count;
            end
            if (st_latch && !st_valid_q) begin
               st_valid_q <= 1'b1;
               st_q       <= status_now;
            end
            if (rd_pop) begin
               if (st_valid_q) begin
                  st_valid_q <= 1'b0;
               end else if (fmt_q == RW_BOTH) begin
                  rd_hi_q <= !rd_hi_q;
                  if (rd_hi_q) frozen_q <= 1'b0;
               end else begin
                  frozen_q <= 1'b0;
               end
            end
         end
      end
   end

   assign load_value = cr_q;
   assign load_pulse = load_q;
   assign cfg_pulse  = cfg_q;
   assign mode       = mode_q;
   assign bcd        = bcd_q;

   // R5: a frozen count stays frozen until it is read or the channel is reprogrammed
   assert_hold_until_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frozen_q && !rd_pop && !cfg_cmd |=> frozen_q);

   // R6: a second latch does not disturb the held value
   assert_relatch_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frozen_q && cnt_latch && !rd_pop && !cfg_cmd |=> frozen_q && $stable(hold_q));

   // R9: a status read consumes only the status byte
   assert_status_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid_q && rd_pop && !cfg_cmd && !st_latch && !cnt_latch
      |=> !st_valid_q && $stable(rd_hi_q) && $stable(frozen_q));

   // R10: a control word leaves the null-count flag set
   assert_cfg_sets_null_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_cmd |=> null_q && cfg_q);

   // R11: a control word resets both byte pointers
   assert_ptr_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_cmd |=> !wr_hi_q && !rd_hi_q && !frozen_q && !st_valid_q);

endmodule

// File: rtl/thp_read_mux.sv
module thp_read_mux #(
   parameter int NUM_CH = 3,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [NUM_CH*BYTE_W-1:0] ch_byte,
   output logic [BYTE_W-1:0]        bus_rdata
);
   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == ADDR_W'(i)) bus_rdata = ch_byte[i*BYTE_W +: BYTE_W];
      end
   end
endmodule

// File: rtl/timer_host_port.sv
module timer_host_port
   import timer_host_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int BYTE_W = 8,
   localparam int ADDR_W = 2,
   localparam int CNT_W  = 2 * BYTE_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [BYTE_W-1:0]        bus_wdata,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   output logic [BYTE_W-1:0]        bus_rdata,
   input  logic [NUM_CH*CNT_W-1:0]  ch_live_count,
   input  logic [NUM_CH-1:0]        ch_out_level,
   input  logic [NUM_CH-1:0]        ch_cr_taken,
   output logic [NUM_CH*CNT_W-1:0]  ch_load_value,
   output logic [NUM_CH-1:0]        ch_load_strobe,
   output logic [NUM_CH-1:0]        ch_cfg_strobe,
   output logic [NUM_CH*MODE_W-1:0] ch_mode,
   output logic [NUM_CH-1:0]        ch_bcd
);
   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_num_ch
      $error("NUM_CH must lie in 1..3 so that the control port stays free");
   end
   if (BYTE_W < 8) begin : g_bad_byte_w
      $error("BYTE_W must be at least 8 to carry a control word");
   end

   logic [NUM_CH-1:0]        cfg_cmd;
   logic [NUM_CH-1:0]        cnt_wr;
   logic [NUM_CH-1:0]        cnt_latch;
   logic [NUM_CH-1:0]        st_latch;
   logic [NUM_CH-1:0]        rd_pop;
   rw_fmt_e                  cw_fmt;
   logic [MODE_W-1:0]        cw_mode;
   logic                     cw_bcd;
   logic [NUM_CH*BYTE_W-1:0] ch_byte;

   thp_cmd_decode #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_decode (
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .cfg_cmd   (cfg_cmd),
      .cnt_wr    (cnt_wr),
      .cnt_latch (cnt_latch),
      .st_latch  (st_latch),
      .rd_pop    (rd_pop),
      .cw_fmt    (cw_fmt),
      .cw_mode   (cw_mode),
      .cw_bcd    (cw_bcd)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      thp_channel #(.BYTE_W(BYTE_W)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .cfg_cmd    (cfg_cmd[i]),
         .cw_fmt     (cw_fmt),
         .cw_mode    (cw_mode),
         .cw_bcd     (cw_bcd),
         .cnt_wr     (cnt_wr[i]),
         .wdata      (bus_wdata),
         .cnt_latch  (cnt_latch[i]),
         .st_latch   (st_latch[i]),
         .rd_pop     (rd_pop[i]),
         .live_count (ch_live_count[i*CNT_W +: CNT_W]),
         .out_level  (ch_out_level[i]),
         .cr_taken   (ch_cr_taken[i]),
         .load_value (ch_load_value[i*CNT_W +: CNT_W]),
         .load_pulse (ch_load_strobe[i]),
         .cfg_pulse  (ch_cfg_strobe[i]),
         .mode       (ch_mode[i*MODE_W +: MODE_W]),
         .bcd        (ch_bcd[i]),
         .rd_byte    (ch_byte[i*BYTE_W +: BYTE_W])
      );
   end

   thp_read_mux #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_rmux (
      .bus_addr  (bus_addr),
      .ch_byte   (ch_byte),
      .bus_rdata (bus_rdata)
   );

   // R3: only one channel can complete a count per cycle
   assert_one_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_load_strobe));

   // R2: a config strobe never lasts more than one cycle
   assert_cfg_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_cfg_strobe[0]) |=> !ch_cfg_strobe[0] || cfg_cmd[0]);

endmodule

// File: tb/timer_host_port_bench.sv
module timer_host_port_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  bus_addr;
   logic [7:0]  bus_wdata;
   logic        bus_wr;
   logic        bus_rd;
   logic [7:0]  bus_rdata;
   logic [15:0] live [3];
   logic [47:0] ch_live_count;
   logic [2:0]  ch_out_level;
   logic [2:0]  ch_cr_taken;
   logic [47:0] ch_load_value;
   logic [2:0]  ch_load_strobe;
   logic [2:0]  ch_cfg_strobe;
   logic [8:0]  ch_mode;
   logic [2:0]  ch_bcd;

   int   checks = 0;
   int   errors = 0;
   bit   done   = 0;
   logic [2:0] seen_load;
   logic [2:0] seen_cfg;
   logic [7:0] rb;

   assign ch_live_count = {live[2], live[1], live[0]};

   always #(CLK_PERIOD/2) clk = !clk;

   timer_host_port u_timer_host_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .ch_live_count(ch_live_count), .ch_out_level(ch_out_level),
      .ch_cr_taken(ch_cr_taken), .ch_load_value(ch_load_value),
      .ch_load_strobe(ch_load_strobe), .ch_cfg_strobe(ch_cfg_strobe),
      .ch_mode(ch_mode), .ch_bcd(ch_bcd)
   );

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      seen_load = ch_load_strobe;
      seen_cfg  = ch_cfg_strobe;
   endtask

   task automatic do_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse_taken(input int ch);
      @(negedge clk);
      ch_cr_taken[ch] = 1'b1;
      @(negedge clk);
      ch_cr_taken = '0;
   endtask

   task automatic t_reset;
      live[0] = 16'hBEEF;
      @(negedge clk);
      check("R1", "mode after reset", {7'd0, ch_mode}, 16'h0);
      check("R1", "bcd/strobes after reset", {7'd0, ch_bcd, ch_load_strobe, ch_cfg_strobe}, 16'h0);
      do_read(2'd0, rb); check("R1", "reset read LSB", {8'd0, rb}, 16'h00EF);
      do_read(2'd0, rb); check("R1", "reset read MSB", {8'd0, rb}, 16'h00BE);
      do_write(2'd3, 8'hE2);
      do_read(2'd0, rb); check("R1", "reset status", {8'd0, rb}, 16'h0030);
   endtask

   task automatic t_program;
      do_write(2'd3, 8'h74);
      check("R2", "cfg strobe ch1", {13'd0, seen_cfg}, 16'h0002);
      check("R2", "mode ch1", {13'd0, ch_mode[5:3]}, 16'h0002);
      @(negedge clk);
      check("R2", "cfg strobe one cycle", {13'd0, ch_cfg_strobe}, 16'h0);
      do_write(2'd1, 8'h50);
      check("R3", "no load after first byte", {13'd0, seen_load}, 16'h0);
      do_write(2'd1, 8'hC3);
      check("R3", "load strobe ch1", {13'd0, seen_load}, 16'h0002);
      check("R3", "load value ch1", ch_load_value[31:16], 16'hC350);
      do_write(2'd3, 8'h97);
      check("R2", "mode ch2", {13'd0, ch_mode[8:6]}, 16'h0003);
      check("R2", "bcd ch2", {15'd0, ch_bcd[2]}, 16'h0001);
      do_write(2'd2, 8'h07);
      check("R3", "LSB-only load", ch_load_value[47:32], 16'h0007);
      check("R3", "LSB-only strobe", {13'd0, seen_load}, 16'h0004);
      do_write(2'd3, 8'hA0);
      do_write(2'd2, 8'h55);
      check("R3", "MSB-only load", ch_load_value[47:32], 16'h5500);
      live[2] = 16'h3344;
      do_read(2'd2, rb); check("R2", "MSB-only read", {8'd0, rb}, 16'h0033);
      live[2] = 16'h7788;
      do_read(2'd2, rb); check("R4", "live follows MSB", {8'd0, rb}, 16'h0077);
   endtask

   task automatic t_null;
      ch_out_level[2] = 1'b1;
      do_write(2'd3, 8'hE8);
      do_read(2'd2, rb); check("R8", "status null set", {8'd0, rb}, 16'h00E0);
      pulse_taken(2);
      do_write(2'd3, 8'hE8);
      do_read(2'd2, rb); check("R10", "null cleared", {8'd0, rb}, 16'h00A0);
      do_write(2'd2, 8'h01);
      do_write(2'd3, 8'hE8);
      do_read(2'd2, rb); check("R10", "null set by count write", {8'd0, rb}, 16'h00E0);
      ch_out_level[2] = 1'b0;
   endtask

   task automatic t_latch;
      do_write(2'd3, 8'h30);
      live[0] = 16'h1234;
      do_write(2'd3, 8'h00);
      live[0] = 16'hABCD;
      do_read(2'd0, rb); check("R5", "latched LSB", {8'd0, rb}, 16'h0034);
      live[0] = 16'h5678;
      do_write(2'd3, 8'h00);
      do_read(2'd0, rb); check("R5", "latched MSB", {8'd0, rb}, 16'h0012);
      do_read(2'd0, rb); check("R4", "released LSB", {8'd0, rb}, 16'h0078);
      do_read(2'd0, rb); check("R4", "released MSB", {8'd0, rb}, 16'h0056);
      live[0] = 16'h1111;
      do_write(2'd3, 8'h00);
      live[0] = 16'h2222;
      do_write(2'd3, 8'h00);
      live[0] = 16'h3333;
      do_read(2'd0, rb); check("R6", "relatch ignored LSB", {8'd0, rb}, 16'h0011);
      do_read(2'd0, rb); check("R6", "relatch ignored MSB", {8'd0, rb}, 16'h0011);
      live[0] = 16'h4444;
      do_write(2'd3, 8'h00);
      live[0] = 16'h5555;
      do_write(2'd3, 8'h30);
      do_read(2'd0, rb); check("R5", "reprogram releases latch", {8'd0, rb}, 16'h0055);
   endtask

   task automatic t_readback;
      pulse_taken(1);
      ch_out_level[1] = 1'b1;
      live[1] = 16'h0102;
      do_write(2'd3, 8'hC4);
      live[1] = 16'h0304;
      ch_out_level[1] = 1'b0;
      do_read(2'd1, rb); check("R9", "status first", {8'd0, rb}, 16'h00B4);
      do_read(2'd1, rb); check("R9", "count LSB after status", {8'd0, rb}, 16'h0002);
      do_read(2'd1, rb); check("R9", "count MSB after status", {8'd0, rb}, 16'h0001);
      do_read(2'd1, rb); check("R4", "follows after read-back", {8'd0, rb}, 16'h0004);
      do_read(2'd1, rb);
      do_write(2'd3, 8'hE4);
      ch_out_level[1] = 1'b1;
      do_write(2'd3, 8'hE4);
      do_read(2'd1, rb); check("R7", "status relatch ignored", {8'd0, rb}, 16'h0034);
      do_read(2'd1, rb); check("R7", "status-only leaves count live", {8'd0, rb}, 16'h0004);
      do_read(2'd1, rb);
      do_write(2'd3, 8'h30);
      do_write(2'd3, 8'hA0);
      live[0] = 16'h0A0B; live[2] = 16'h0C0D;
      do_write(2'd3, 8'hDA);
      live[0] = 16'h0000; live[2] = 16'h0000;
      do_read(2'd0, rb); check("R7", "multi read-back ch0 LSB", {8'd0, rb}, 16'h000B);
      do_read(2'd0, rb); check("R7", "multi read-back ch0 MSB", {8'd0, rb}, 16'h000A);
      do_read(2'd2, rb); check("R7", "multi read-back ch2 MSB", {8'd0, rb}, 16'h000C);
      do_read(2'd2, rb); check("R5", "ch2 released after one byte", {8'd0, rb}, 16'h0000);
   endtask

   task automatic t_pointers;
      do_write(2'd3, 8'h30);
      do_write(2'd0, 8'h11);
      do_write(2'd3, 8'h30);
      do_write(2'd0, 8'h22);
      check("R11", "write pointer reset: no load", {13'd0, seen_load}, 16'h0);
      do_write(2'd0, 8'h33);
      check("R11", "load after pointer reset", ch_load_value[15:0], 16'h3322);
      live[0] = 16'h789A;
      do_read(2'd0, rb);
      do_write(2'd3, 8'h30);
      do_read(2'd0, rb); check("R11", "read pointer reset", {8'd0, rb}, 16'h009A);
      do_write(2'd3, 8'h30);
      do_read(2'd3, rb); check("R12", "control read value", {8'd0, rb}, 16'h0000);
      do_read(2'd0, rb); check("R12", "pointer untouched", {8'd0, rb}, 16'h009A);
   endtask

   initial begin
      rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
      ch_out_level = '0; ch_cr_taken = '0;
      live[0] = '0; live[1] = '0; live[2] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_program();
      t_null();
      t_latch();
      t_readback();
      t_pointers();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule